// File: doc/BRIEF.md
# Dual-Channel Keyboard/Mouse Host Register Block

This block gives a processor a register view of two serial input-device channels: channel 0 for a keyboard, channel 1 for a mouse. Each channel has four byte-wide registers, placed 8 bytes apart. They are a transmit buffer, a receive buffer, a control register and a status register. Each channel also has its own receive queue and its own interrupt line.

Line timing is not modelled. A command byte written to a channel's transmit buffer goes to an internal responder. The responder pushes the bytes that an attached device would send back: one byte, two bytes, or none. Software reads these bytes from the receive buffer. It can take them by polling the status register or when the channel's interrupt is raised.

Reads are combinational. `rdata_o` is valid while `rd_i` is high, and a receive pop takes effect at the clock edge. `wr_i` and `rd_i` are never high in the same cycle.

Top module: `ps2_dual_regs`

## Requirements
- R1: The byte address is decoded as follows. Bits [4:3] select the register: 0 is transmit, 1 is receive, 2 is control, 3 is status. Bit 5 selects the channel: 0 is keyboard, 1 is mouse. Bits [2:0] are ignored.
- R2: A control write stores, for the addressed channel only, three flags. Bit 4 is the clock flag, bit 3 is the receive interrupt enable and bit 2 is the transmit interrupt enable. A control read returns these flags in the same bit positions, with all other bits 0.
- R3: After reset all flags are 0, both queues are empty, both interrupts are low, and a status read returns 0x08.
- R4: A status read returns the clock flag in bit 0. Bit 3 is always 1. Bit 4 is 1 when that channel's queue holds data. All other bits are 0.
- R5: A receive read returns the oldest queued byte of the channel and removes it. If the queue is empty, the read returns 0x00 and changes nothing.
- R6: A transmit write of 0xF2 queues 0xAB and then 0x83. A transmit write of 0xFF queues 0xFA and then 0xAA.
- R7: A transmit write of 0xED, 0xF3, 0xF4, 0xF5, 0xF6, 0xFA or 0xFC queues 0xFA. A transmit write of 0xF0, 0x00, 0x03, 0x04, 0x14, 0x28 or 0x76 queues 0x03. Any other byte queues nothing.
- R8: Each queue holds DEPTH bytes. A reply byte that finds the queue full is dropped, and the bytes already held stay unchanged. In a two-byte reply with room for only one byte, the first byte is kept.
- R9: Interrupt c is high exactly when queue c holds data and the receive interrupt enable of channel c is set.
- R10: Writes to the receive or status register have no effect. A transmit read returns 0x00.
- R11: The two channels are independent. Accesses to one channel never change the other channel's queue or flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe; a receive read pops at the clock edge |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid while rd_i is high |
| irq_o | output | 2 | Receive interrupt per channel, bit 0 for keyboard |

## Verification
The hardest state to reach from the ports is a two-byte reply arriving when a queue has exactly one free slot. This requires 255 bytes to be queued first. The stimulus gets there directly: it issues 127 identify commands and one single-byte command. It then issues another identify command, which must keep 0xAB and drop 0x83, followed by a reset command that must be dropped completely. After that it drains all 256 bytes in order. Random traffic, with command bytes biased toward the known codes, covers mixing between the channels and random values in the ignored low address bits.

// File: rtl/ps2_dual_pkg.sv
package ps2_dual_pkg;
  typedef enum logic [1:0] {
    REG_TX   = 2'd0,
    REG_RX   = 2'd1,
    REG_CTRL = 2'd2,
    REG_STAT = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [1:0] n;   // bytes to queue: 0..2
    logic [7:0] b0;
    logic [7:0] b1;
  } reply_t;

  localparam int CTRL_CLK_BIT = 4;
  localparam int CTRL_RXIE_BIT = 3;
  localparam int CTRL_TXIE_BIT = 2;
  localparam int STAT_CLK_BIT = 0;
  localparam int STAT_TXE_BIT = 3;
  localparam int STAT_RXA_BIT = 4;
endpackage

// File: rtl/ps2_responder.sv
module ps2_responder
  import ps2_dual_pkg::*;
(
  input  logic [7:0] cmd_i,
  output reply_t     reply_o
);
  always_comb begin
    reply_o = '0;
    unique case (cmd_i)
      8'hF2: reply_o = '{n: 2'd2, b0: 8'hAB, b1: 8'h83};
      8'hFF: reply_o = '{n: 2'd2, b0: 8'hFA, b1: 8'hAA};
      8'hED, 8'hF3, 8'hF4, 8'hF5, 8'hF6, 8'hFA, 8'hFC:
        reply_o = '{n: 2'd1, b0: 8'hFA, b1: 8'h00};
      8'hF0, 8'h00, 8'h03, 8'h04, 8'h14, 8'h28, 8'h76:
        reply_o = '{n: 2'd1, b0: 8'h03, b1: 8'h00};
      default: reply_o = '0;
    endcase
  end
endmodule

// File: rtl/ps2_rx_queue.sv
module ps2_rx_queue #(
  parameter int DEPTH = 256,           // power of two, >= 2
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       push_n_i,
  input  logic [7:0]       push_d0_i,
  input  logic [7:0]       push_d1_i,
  input  logic             pop_i,
  output logic [7:0]       head_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q, free;
  logic             take0, take1, pop_ok;

  always_comb begin
    free   = CNT_W'(DEPTH) - cnt_q;
    take0  = (push_n_i != 2'd0) && (free >= CNT_W'(1));
    take1  = (push_n_i == 2'd2) && (free >= CNT_W'(2));
    pop_ok = pop_i && (cnt_q != '0);
  end

  always_ff @(posedge clk_i) begin
    if (take0) mem[wr_ptr_q] <= push_d0_i;
    if (take1) mem[wr_ptr_q + PTR_W'(1)] <= push_d1_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_q + PTR_W'(take0) + PTR_W'(take1);
      if (pop_ok) rd_ptr_q <= rd_ptr_q + PTR_W'(1);
      cnt_q <= cnt_q + CNT_W'(take0) + CNT_W'(take1) - CNT_W'(pop_ok);
    end
  end

  assign head_o = (cnt_q != '0) ? mem[rd_ptr_q] : 8'h00;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/ps2_dual_regs.sv
module ps2_dual_regs
  import ps2_dual_pkg::*;
#(
  parameter int ADDR_W = 6,            // >= 6
  parameter int DEPTH  = 256,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int NCH   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic [NCH-1:0]    irq_o
);
  reg_sel_e                   sel;
  logic                       ch;
  reply_t                     reply;
  logic [NCH-1:0][CNT_W-1:0]  q_cnt;
  logic [NCH-1:0][7:0]        q_head;
  logic [NCH-1:0]             clk_flag, rx_ie, tx_ie;

  assign sel = reg_sel_e'(addr_i[4:3]);
  assign ch  = addr_i[5];

  ps2_responder u_resp (.cmd_i(wdata_i), .reply_o(reply));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic       hit;
    logic [1:0] push_n;
    logic       pop;

    assign hit    = (ch == 1'(c));
    assign push_n = (wr_i && hit && sel == REG_TX) ? reply.n : 2'd0;
    assign pop    = rd_i && hit && sel == REG_RX;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        clk_flag[c] <= 1'b0;
        rx_ie[c]    <= 1'b0;
        tx_ie[c]    <= 1'b0;
      end else if (wr_i && hit && sel == REG_CTRL) begin
        clk_flag[c] <= wdata_i[CTRL_CLK_BIT];
        rx_ie[c]    <= wdata_i[CTRL_RXIE_BIT];
        tx_ie[c]    <= wdata_i[CTRL_TXIE_BIT];
      end
    end

    ps2_rx_queue #(.DEPTH(DEPTH)) u_q (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .push_n_i (push_n),
      .push_d0_i(reply.b0),
      .push_d1_i(reply.b1),
      .pop_i    (pop),
      .head_o   (q_head[c]),
      .cnt_o    (q_cnt[c])
    );

    assign irq_o[c] = (q_cnt[c] != '0) && rx_ie[c];
  end

  always_comb begin
    rdata_o = 8'h00;
    if (rd_i) begin
      unique case (sel)
        REG_RX: rdata_o = q_head[ch];
        REG_CTRL: begin
          rdata_o[CTRL_CLK_BIT]  = clk_flag[ch];
          rdata_o[CTRL_RXIE_BIT] = rx_ie[ch];
          rdata_o[CTRL_TXIE_BIT] = tx_ie[ch];
        end
        REG_STAT: begin
          rdata_o[STAT_CLK_BIT] = clk_flag[ch];
          rdata_o[STAT_TXE_BIT] = 1'b1;
          rdata_o[STAT_RXA_BIT] = (q_cnt[ch] != '0);
        end
        default: rdata_o = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/ps2_dual_regs_chk.sv
module ps2_dual_regs_chk #(
  parameter int ADDR_W = 6,
  parameter int DEPTH  = 256,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [ADDR_W-1:0]     addr_i,
  input logic                  wr_i,
  input logic                  rd_i,
  input logic [7:0]            wdata_i,
  input logic [7:0]            rdata_o,
  input logic [1:0]            irq_o,
  input logic [1:0][CNT_W-1:0] q_cnt
);
  a_r4_status_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i[4:3] == 2'd3) |-> (rdata_o[3] && rdata_o[7:5] == 3'd0 && rdata_o[2:1] == 2'd0));

  for (genvar c = 0; c < 2; c++) begin : g_c
    a_r9_irq_needs_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[c] |-> (q_cnt[c] != '0));

    a_r8_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      q_cnt[c] <= CNT_W'(DEPTH));

    a_r5_pop_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_i && !wr_i && addr_i[5] == 1'(c) && addr_i[4:3] == 2'd1 && q_cnt[c] != '0)
      |=> (q_cnt[c] == $past(q_cnt[c]) - CNT_W'(1)));

    a_r6_two_byte_reply: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && !rd_i && addr_i[5] == 1'(c) && addr_i[4:3] == 2'd0 && wdata_i == 8'hF2
       && q_cnt[c] <= CNT_W'(DEPTH - 2))
      |=> (q_cnt[c] == $past(q_cnt[c]) + CNT_W'(2)));

    a_r10_rx_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && !rd_i && addr_i[4:3] == 2'd1) |=> $stable(q_cnt[c]));
  end
endmodule

bind ps2_dual_regs ps2_dual_regs_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .addr_i (addr_i),
  .wr_i   (wr_i),
  .rd_i   (rd_i),
  .wdata_i(wdata_i),
  .rdata_o(rdata_o),
  .irq_o  (irq_o),
  .q_cnt  (q_cnt)
);

// File: tb/ps2_dual_regs_test.sv
module ps2_dual_regs_test;
  localparam int DEPTH = 256;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [5:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [1:0] irq;

  int n_chk = 0, n_fail = 0;
  logic [7:0] mq [2][$];
  logic [1:0] m_clk = '0, m_rx = '0, m_tx = '0;

  always #4 clk = ~clk;

  ps2_dual_regs #(.ADDR_W(6), .DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic int rep_n(input logic [7:0] b);
    case (b)
      8'hF2, 8'hFF: return 2;
      8'hED, 8'hF3, 8'hF4, 8'hF5, 8'hF6, 8'hFA, 8'hFC,
      8'hF0, 8'h00, 8'h03, 8'h04, 8'h14, 8'h28, 8'h76: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic logic [7:0] rep_b(input logic [7:0] b, input int i);
    if (b == 8'hF2) return (i == 0) ? 8'hAB : 8'h83;
    if (b == 8'hFF) return (i == 0) ? 8'hFA : 8'hAA;
    if (b inside {8'hF0, 8'h00, 8'h03, 8'h04, 8'h14, 8'h28, 8'h76}) return 8'h03;
    return 8'hFA;
  endfunction

  function automatic logic [7:0] exp_stat(input int c);
    return {3'b000, mq[c].size() != 0, 1'b1, 2'b00, m_clk[c]};
  endfunction

  task automatic do_wr(input int c, input int sel, input logic [7:0] d, input logic [2:0] lo);
    @(negedge clk);
    addr = {1'(c), 2'(sel), lo}; wdata = d; wr = 1'b1;
    @(posedge clk); #1 wr = 1'b0;
    if (sel == 0) begin
      for (int i = 0; i < rep_n(d); i++)
        if (mq[c].size() < DEPTH) mq[c].push_back(rep_b(d, i));
    end else if (sel == 2) begin
      m_clk[c] = d[4]; m_rx[c] = d[3]; m_tx[c] = d[2];
    end
  endtask

  task automatic do_rd(input int c, input int sel, input logic [2:0] lo, input string req);
    logic [7:0] e;
    @(negedge clk);
    addr = {1'(c), 2'(sel), lo}; rd = 1'b1;
    case (sel)
      0: e = 8'h00;
      1: e = (mq[c].size() != 0) ? mq[c][0] : 8'h00;
      2: e = {3'b000, m_clk[c], m_rx[c], m_tx[c], 2'b00};
      default: e = exp_stat(c);
    endcase
    #1 chk(req, rdata, e);
    @(posedge clk); #1 rd = 1'b0;
    if (sel == 1 && mq[c].size() != 0) void'(mq[c].pop_front());
  endtask

  task automatic chk_irq(input string req);
    @(negedge clk);
    chk(req, {6'd0, irq}, {6'd0, m_rx[1] && mq[1].size() != 0, m_rx[0] && mq[0].size() != 0});
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    logic [7:0] cmds [16] = '{8'hF2, 8'hFF, 8'hED, 8'hF3, 8'hF4, 8'hF5, 8'hF6, 8'hFA,
                             8'hFC, 8'hF0, 8'h00, 8'h03, 8'h04, 8'h14, 8'h28, 8'h76};
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;

    // R3 reset state
    chk("R3 irq", {6'd0, irq}, 8'h00);
    do_rd(0, 3, 3'd0, "R3 status ch0");
    do_rd(1, 3, 3'd0, "R3 status ch1");
    do_rd(0, 2, 3'd0, "R3 ctrl ch0");
    do_rd(1, 1, 3'd0, "R5 empty rx returns 0");

    // R2 control flags, R11 independence
    do_wr(0, 2, 8'h1C, 3'd0);
    do_rd(0, 2, 3'd0, "R2 ctrl readback");
    do_rd(1, 2, 3'd0, "R11 ctrl ch1 untouched");
    do_rd(0, 3, 3'd0, "R4 clock flag in status");

    // R6 two-byte replies, R9 irq
    do_wr(0, 0, 8'hF2, 3'd0);
    chk_irq("R9 irq ch0 raised");
    do_rd(1, 3, 3'd0, "R11 ch1 status empty");
    do_rd(0, 1, 3'd0, "R6 identify byte0");
    do_rd(0, 1, 3'd0, "R6 identify byte1");
    chk_irq("R9 irq ch0 cleared");
    do_wr(1, 0, 8'hFF, 3'd0);
    do_rd(1, 1, 3'd0, "R6 reset byte0");
    do_rd(1, 1, 3'd0, "R6 reset byte1");

    // R7 single-byte and unknown
    do_wr(1, 0, 8'h55, 3'd0);
    do_rd(1, 3, 3'd0, "R7 unknown queues nothing");
    do_wr(1, 0, 8'h76, 3'd0);
    do_wr(1, 0, 8'hF4, 3'd0);
    do_rd(1, 1, 3'd0, "R7 arg byte 0x03");
    do_rd(1, 1, 3'd0, "R7 ack 0xFA");

    // R10 ignored writes, R1 low address bits
    do_wr(0, 0, 8'hED, 3'd5);
    do_wr(0, 1, 8'h00, 3'd0);
    do_wr(0, 3, 8'hFF, 3'd0);
    do_rd(0, 3, 3'd7, "R10 status after ignored writes");
    do_rd(0, 0, 3'd2, "R10 tx read zero");
    do_rd(0, 1, 3'd6, "R1 low bits ignored");

    // R8 fill to one free slot, then two-byte reply
    for (int i = 0; i < 127; i++) do_wr(1, 0, 8'hF2, 3'd0);
    do_wr(1, 0, 8'hF4, 3'd0);
    do_wr(1, 0, 8'hF2, 3'd0);
    do_wr(1, 0, 8'hFF, 3'd0);
    chk("R8 model depth", 8'(mq[1].size() == DEPTH), 8'h01);
    for (int i = 0; i < DEPTH; i++) do_rd(1, 1, 3'd0, "R8 drain order");
    do_rd(1, 3, 3'd0, "R8 empty after drain");

    // random mix
    for (int k = 0; k < 4000; k++) begin
      int c = int'($urandom % 2);
      int s = int'($urandom % 4);
      logic [2:0] lo = 3'($urandom);
      if ($urandom % 2 == 0) begin
        logic [7:0] d = ($urandom % 4 != 0) ? cmds[$urandom % 16] : 8'($urandom);
        if (s == 2) d = 8'($urandom);
        do_wr(c, s, d, lo);
      end else begin
        do_rd(c, s, lo, (s == 1) ? "R5 random rx" : (s == 3) ? "R4 random status" : "R2 random ctrl/tx");
      end
      if (k % 8 == 0) chk_irq("R9 random irq");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule